// File: doc/BRIEF.md
# Nonvolatile Store/Restore Sequencer

This block sequences every transfer between two wiper registers and the nonvolatile words behind them, plus a small user data area. The nonvolatile array is modelled as flip-flops. Each kind of transfer holds a ready output low for its own programmable number of cycles, so the surrounding logic sees the same busy windows that real nonvolatile writes and reads would impose. A command's effect lands in the cycle its busy window closes.

After reset the block restores both wipers from their shadow words before it reports ready. The shadow words start at midscale until new values are stored. A rising edge on the preset input repeats that restore. A write-protect input blocks every command that would change wiper or array contents. Restores from the shadow words, whether by command or by preset, still run while protection is active.

Commands arrive as single-cycle pulses with a 4-bit code, an address and a data word. A command or preset edge that arrives while the block is busy is dropped, and a one-cycle error pulse marks it. The states are `S_BOOT` (first cycle after reset), `S_IDLE` (ready high) and `S_BUSY` (a timed operation is running). The transitions are:
- boot-start: `S_BOOT` to `S_BUSY`, always.
- accept: `S_IDLE` to `S_BUSY`, on a preset edge or on a timed command.
- finish: `S_BUSY` to `S_IDLE`, when the busy counter expires.

Top module: `nv_store_seq`

## Requirements
- R1: Reset sets all of the following. Ready stays low for PRESET_CYC+1 cycles after reset is released, and both wipers then read midscale (2^(WIPER_W-1)). Shadow words 0 and 1 read midscale and user words 2 and up read zero.
- R2: Codes 1 and 11 act immediately, with ready staying high. Code 1 copies the selected shadow word into the selected wiper. Code 11 writes cmd_data into the selected wiper.
- R3: Code 2 copies the selected wiper into its shadow word. Ready stays low for LONG_CYC cycles, and the copy happens when ready returns high.
- R4: Code 3 writes cmd_data into the array word at cmd_addr, with ready low for LONG_CYC cycles. Words 0 and 1 keep all WIPER_W bits. User words keep only the low USER_W bits and read back zero-extended.
- R5: Code 8 loads both wipers from shadow words 0 and 1, with ready low for MID_CYC cycles. Neither wiper changes while ready is low except on the edge that ends the window.
- R6: Code 9 returns the array word at cmd_addr, and code 10 returns the selected wiper. Each holds ready low for SHORT_CYC cycles. rd_valid is high for exactly the one cycle in which ready returns high, and rd_data carries the value.
- R7: A low-to-high transition of preset_in in idle loads both wipers from shadow words 0 and 1, with ready low for PRESET_CYC cycles. A steady level or a falling edge does nothing.
- R8: With wp_n low, codes 2, 3 and 11 are dropped: ready stays high and no wiper or array word changes. Codes 1 and 8 and the preset edge still work.
- R9: A command (cmd_valid high, any code) or a preset rising edge that arrives while ready is low is ignored. err is high in the following cycle.
- R10: If a preset rising edge and a command arrive in the same idle cycle, the preset is carried out, the command is dropped and err is high in the following cycle.
- R11: Codes 0, 4 to 7 and 12 to 15 are dropped, and so are codes 3 and 9 with cmd_addr of USER_WORDS+2 or more. A dropped command leaves ready high and raises no error.
- R12: The wiper-select commands (1, 2, 10 and 11) use cmd_addr bit 0 to choose the wiper: 0 selects wiper0 and 1 selects wiper1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Array address, or wiper select in bit 0 |
| cmd_data | input | WIPER_W | Data for array or wiper writes |
| preset_in | input | 1 | Restore request, acts on its rising edge |
| wp_n | input | 1 | Active-low write protect |
| ready | output | 1 | High when idle, low during timed operations |
| err | output | 1 | One-cycle pulse for a request dropped while busy |
| rd_valid | output | 1 | One-cycle pulse when rd_data is fresh |
| rd_data | output | WIPER_W | Result of the last read command |
| wiper0 | output | WIPER_W | Wiper register 0 |
| wiper1 | output | WIPER_W | Wiper register 1 |

## Verification
The bench builds the block with busy windows of 12, 6, 3 and 5 cycles for the long, mid, short and preset classes. It keeps 10-bit wipers and the full 26-word user area, so every window can be counted cycle by cycle against its parameter. At this size the bench writes and reads back every array address, sweeps all sixteen command codes, and runs the out-of-range addresses just past the array. It also drives the collisions between a busy window, a second command and a preset edge in a few hundred cycles.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        S_BOOT,
        S_IDLE,
        S_BUSY
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD1,
        OP_SET,
        OP_STORE,
        OP_WRNV,
        OP_LOADALL,
        OP_RDNV,
        OP_RDWIP
    } op_t;

    typedef enum logic [1:0] {
        DUR_LONG,
        DUR_MID,
        DUR_SHORT,
        DUR_PRESET
    } dur_t;

    localparam logic [3:0] CODE_LOAD1   = 4'd1;
    localparam logic [3:0] CODE_STORE   = 4'd2;
    localparam logic [3:0] CODE_WRNV    = 4'd3;
    localparam logic [3:0] CODE_LOADALL = 4'd8;
    localparam logic [3:0] CODE_RDNV    = 4'd9;
    localparam logic [3:0] CODE_RDWIP   = 4'd10;
    localparam logic [3:0] CODE_SET     = 4'd11;

endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
    import nvs_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int NV_WORDS = 28
) (
    input  logic [3:0]        code,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_n,
    output op_t               op,
    output dur_t              dur,
    output logic              timed
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NV_WORDS);

    logic addr_ok;

    assign addr_ok = ({1'b0, addr} < LIMIT);

    always_comb begin
        op  = OP_NONE;
        dur = DUR_SHORT;
        case (code)
            CODE_LOAD1:   op = OP_LOAD1;
            CODE_STORE: begin
                op  = wp_n ? OP_STORE : OP_NONE;
                dur = DUR_LONG;
            end
            CODE_WRNV: begin
                op  = (wp_n && addr_ok) ? OP_WRNV : OP_NONE;
                dur = DUR_LONG;
            end
            CODE_LOADALL: begin
                op  = OP_LOADALL;
                dur = DUR_MID;
            end
            CODE_RDNV:    op = addr_ok ? OP_RDNV : OP_NONE;
            CODE_RDWIP:   op = OP_RDWIP;
            CODE_SET:     op = wp_n ? OP_SET : OP_NONE;
            default:      op = OP_NONE;
        endcase
    end

    assign timed = (op == OP_STORE) || (op == OP_WRNV) || (op == OP_LOADALL)
                || (op == OP_RDNV)  || (op == OP_RDWIP);

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer
    import nvs_pkg::*;
#(
    parameter int LONG_CYC   = 200000,
    parameter int MID_CYC    = 10000,
    parameter int SHORT_CYC  = 1000,
    parameter int PRESET_CYC = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  dur_t dur,
    output logic done
);

    localparam int MAX_AB = (LONG_CYC > MID_CYC) ? LONG_CYC : MID_CYC;
    localparam int MAX_CD = (SHORT_CYC > PRESET_CYC) ? SHORT_CYC : PRESET_CYC;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_val;

    always_comb begin
        unique case (dur)
            DUR_LONG:   start_val = CNT_W'(LONG_CYC);
            DUR_MID:    start_val = CNT_W'(MID_CYC);
            DUR_SHORT:  start_val = CNT_W'(SHORT_CYC);
            DUR_PRESET: start_val = CNT_W'(PRESET_CYC);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int WIPER_W  = 10,
    parameter int USER_W   = 8,
    parameter int NV_WORDS = 28,
    parameter int ADDR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [WIPER_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [WIPER_W-1:0] rdata,
    output logic [WIPER_W-1:0] shadow0,
    output logic [WIPER_W-1:0] shadow1
);

    localparam int DEPTH                 = 1 << ADDR_W;
    localparam logic [WIPER_W-1:0] MIDV  = WIPER_W'(1) << (WIPER_W - 1);
    localparam logic [WIPER_W-1:0] UMASK = WIPER_W'((1 << USER_W) - 1);

    logic [WIPER_W-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        if (i < 2) begin : g_shadow
            logic [WIPER_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= MIDV;
                end else if (we && waddr == ADDR_W'(i)) begin
                    q <= wdata;
                end
            end
            assign words[i] = q;
        end else if (i < NV_WORDS) begin : g_user
            logic [WIPER_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && waddr == ADDR_W'(i)) begin
                    q <= wdata & UMASK;
                end
            end
            assign words[i] = q;
        end else begin : g_pad
            assign words[i] = '0;
        end
    end

    assign rdata   = words[raddr];
    assign shadow0 = words[0];
    assign shadow1 = words[1];

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
    import nvs_pkg::*;
#(
    parameter int WIPER_W    = 10,
    parameter int USER_W     = 8,
    parameter int USER_WORDS = 26,
    parameter int LONG_CYC   = 200000,
    parameter int MID_CYC    = 10000,
    parameter int SHORT_CYC  = 1000,
    parameter int PRESET_CYC = 700,
    localparam int NV_WORDS  = USER_WORDS + 2,
    localparam int ADDR_W    = $clog2(NV_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [3:0]         cmd_code,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [WIPER_W-1:0] cmd_data,
    input  logic               preset_in,
    input  logic               wp_n,
    output logic               ready,
    output logic               err,
    output logic               rd_valid,
    output logic [WIPER_W-1:0] rd_data,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1
);

    seq_state_t state_q, state_d;

    op_t                dec_op;
    dur_t               dec_dur;
    logic               dec_timed;
    op_t                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WIPER_W-1:0] data_q;
    logic               preset_q;
    logic               preset_rise;
    logic               is_idle;
    logic               accept;
    logic               finish;
    logic               imm;
    logic               tmr_load;
    dur_t               tmr_dur;
    logic               tmr_done;
    logic               nv_we;
    logic [ADDR_W-1:0]  nv_waddr;
    logic [WIPER_W-1:0] nv_wdata;
    logic [WIPER_W-1:0] nv_rdata;
    logic [WIPER_W-1:0] sh0, sh1;
    logic [WIPER_W-1:0] w0_q, w1_q;

    nvs_decode #(
        .ADDR_W  (ADDR_W),
        .NV_WORDS(NV_WORDS)
    ) u_decode (
        .code (cmd_code),
        .addr (cmd_addr),
        .wp_n (wp_n),
        .op   (dec_op),
        .dur  (dec_dur),
        .timed(dec_timed)
    );

    assign preset_rise = preset_in && !preset_q;
    assign is_idle     = (state_q == S_IDLE);
    assign accept      = is_idle && (preset_rise || (cmd_valid && dec_timed));
    assign imm         = is_idle && !preset_rise && cmd_valid
                      && ((dec_op == OP_LOAD1) || (dec_op == OP_SET));
    assign finish      = (state_q == S_BUSY) && tmr_done;
    assign tmr_load    = (state_q == S_BOOT) || accept;
    assign tmr_dur     = ((state_q == S_BOOT) || preset_rise) ? DUR_PRESET : dec_dur;

    nvs_timer #(
        .LONG_CYC  (LONG_CYC),
        .MID_CYC   (MID_CYC),
        .SHORT_CYC (SHORT_CYC),
        .PRESET_CYC(PRESET_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .dur  (tmr_dur),
        .done (tmr_done)
    );

    assign nv_we    = finish && ((op_q == OP_STORE) || (op_q == OP_WRNV));
    assign nv_waddr = (op_q == OP_STORE) ? ADDR_W'(addr_q[0]) : addr_q;
    assign nv_wdata = (op_q == OP_STORE) ? (addr_q[0] ? w1_q : w0_q) : data_q;

    nvs_array #(
        .WIPER_W (WIPER_W),
        .USER_W  (USER_W),
        .NV_WORDS(NV_WORDS),
        .ADDR_W  (ADDR_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (nv_we),
        .waddr  (nv_waddr),
        .wdata  (nv_wdata),
        .raddr  (addr_q),
        .rdata  (nv_rdata),
        .shadow0(sh0),
        .shadow1(sh1)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: boot-start, accept, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT: state_d = S_BUSY;
            S_IDLE: if (accept) state_d = S_BUSY;
            S_BUSY: if (tmr_done) state_d = S_IDLE;
            default: state_d = S_BOOT;
        endcase
    end

    // Operation latch and preset edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            addr_q   <= '0;
            data_q   <= '0;
            preset_q <= 1'b1;
        end else begin
            preset_q <= preset_in;
            if (state_q == S_BOOT) begin
                op_q <= OP_LOADALL;
            end else if (accept) begin
                if (preset_rise) begin
                    op_q <= OP_LOADALL;
                end else begin
                    op_q   <= dec_op;
                    addr_q <= cmd_addr;
                    data_q <= cmd_data;
                end
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
        end else begin
            err      <= (!is_idle && (cmd_valid || preset_rise))
                     || (is_idle && preset_rise && cmd_valid);
            rd_valid <= finish && ((op_q == OP_RDNV) || (op_q == OP_RDWIP));
            if (finish && op_q == OP_RDNV) begin
                rd_data <= nv_rdata;
            end else if (finish && op_q == OP_RDWIP) begin
                rd_data <= addr_q[0] ? w1_q : w0_q;
            end
            if (finish && op_q == OP_LOADALL) begin
                w0_q <= sh0;
                w1_q <= sh1;
            end else if (imm) begin
                if (dec_op == OP_LOAD1) begin
                    if (cmd_addr[0]) w1_q <= sh1;
                    else             w0_q <= sh0;
                end else begin
                    if (cmd_addr[0]) w1_q <= cmd_data;
                    else             w0_q <= cmd_data;
                end
            end
        end
    end

    assign ready  = is_idle;
    assign wiper0 = w0_q;
    assign wiper1 = w1_q;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int WIPER_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [3:0]         cmd_code,
    input logic               preset_in,
    input logic               wp_n,
    input logic               ready,
    input logic               err,
    input logic               rd_valid,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1
);

    AST_BUSY_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && cmd_valid) |=> err); // R9

    AST_WIPERS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready || ($stable(wiper0) && $stable(wiper1)))); // R5

    AST_RDV_AT_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(ready)); // R6

    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_valid && !wp_n && !(preset_in && !$past(preset_in))
         && (cmd_code == 4'd2 || cmd_code == 4'd3 || cmd_code == 4'd11))
        |=> (ready && $stable(wiper0) && $stable(wiper1))); // R8

endmodule

bind nv_store_seq nvs_checker #(.WIPER_W(WIPER_W)) u_nvs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .preset_in(preset_in),
    .wp_n     (wp_n),
    .ready    (ready),
    .err      (err),
    .rd_valid (rd_valid),
    .wiper0   (wiper0),
    .wiper1   (wiper1)
);

// File: tb/nv_store_seq_bench.sv
module nv_store_seq_bench;

    localparam int WW    = 10;
    localparam int UW    = 8;
    localparam int UWDS  = 26;
    localparam int LONG  = 12;
    localparam int MID   = 6;
    localparam int SHORT = 3;
    localparam int PRE   = 5;
    localparam int NVW   = UWDS + 2;
    localparam int AW    = $clog2(NVW);
    localparam int MIDV  = 1 << (WW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [WW-1:0] cmd_data = '0;
    logic          preset_in = 1'b0;
    logic          wp_n = 1'b1;
    logic          ready, err, rd_valid;
    logic [WW-1:0] rd_data, wiper0, wiper1;

    int n_chk = 0;
    int n_bad = 0;
    int nv_m [32];
    int w_m  [2];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nv_store_seq #(
        .WIPER_W(WW), .USER_W(UW), .USER_WORDS(UWDS),
        .LONG_CYC(LONG), .MID_CYC(MID), .SHORT_CYC(SHORT), .PRESET_CYC(PRE)
    ) u_nv_store_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .preset_in(preset_in),
        .wp_n(wp_n), .ready(ready), .err(err), .rd_valid(rd_valid),
        .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_wipers(input string tag);
        check({tag, " wiper0"}, int'(wiper0), w_m[0]);
        check({tag, " wiper1"}, int'(wiper1), w_m[1]);
    endtask

    function automatic int exp_busy(input int code, input int addr, input bit wp);
        bit ok = addr < NVW;
        case (code)
            2:       return wp ? LONG : 0;
            3:       return (wp && ok) ? LONG : 0;
            8:       return MID;
            9:       return ok ? SHORT : 0;
            10:      return SHORT;
            default: return 0;
        endcase
    endfunction

    // Issue one command, count ready-low cycles, then apply the requirement model
    task automatic do_cmd(input int code, input int addr, input int data, input string tag);
        int busy = 0;
        int eb;
        int sel = addr % 2;
        bit wp = wp_n;
        bit rv_exp = 1'b0;
        int rd_exp = 0;
        eb = exp_busy(code, addr, wp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'(code); cmd_addr = AW'(addr); cmd_data = WW'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " err"}, int'(err), 0);
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        check({tag, " busy cycles"}, busy, eb);
        case (code)
            1: w_m[sel] = nv_m[sel];
            2: if (wp) nv_m[sel] = w_m[sel];
            3: if (wp && addr < NVW) nv_m[addr] = (addr < 2) ? data : (data & ((1 << UW) - 1));
            8: begin w_m[0] = nv_m[0]; w_m[1] = nv_m[1]; end
            9: if (addr < NVW) begin rv_exp = 1'b1; rd_exp = nv_m[addr]; end
            10: begin rv_exp = 1'b1; rd_exp = w_m[sel]; end
            11: if (wp) w_m[sel] = data;
            default: ;
        endcase
        check({tag, " rd_valid"}, int'(rd_valid), int'(rv_exp));
        if (rv_exp) check({tag, " rd_data"}, int'(rd_data), rd_exp);
        check_wipers(tag);
    endtask

    task automatic nv_read(input int addr, input string tag);
        do_cmd(9, addr, 0, tag);
    endtask

    task automatic do_preset_rise(input string tag);
        int busy = 0;
        @(negedge clk);
        preset_in = 1'b1;
        @(negedge clk);
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        check({tag, " preset busy"}, busy, PRE);
        w_m[0] = nv_m[0]; w_m[1] = nv_m[1];
        check_wipers(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int busy;
        for (int i = 0; i < 32; i++) nv_m[i] = (i < 2) ? MIDV : 0;
        w_m[0] = MIDV; w_m[1] = MIDV;

        // R1: boot restore window and reset contents
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        busy = 0;
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        check("R1 boot busy", busy, PRE + 1);
        check_wipers("R1 boot");
        check("R1 err", int'(err), 0);
        for (int a = 0; a < NVW; a++) nv_read(a, "R1 R6 reset word");

        // R4: write and read back every array word
        for (int a = 0; a < NVW; a++) do_cmd(3, a, (a * 37 + 901) % 1024, "R4 write");
        for (int a = 0; a < NVW; a++) nv_read(a, "R4 readback");

        // R5: restore both from the written shadow words
        do_cmd(8, 0, 0, "R5 load all");

        // R2 R12: immediate wiper writes select by address bit 0
        do_cmd(11, 2, 100, "R2 R12 set w0");
        do_cmd(11, 3, 200, "R2 R12 set w1");
        do_cmd(10, 0, 0, "R6 R12 read w0");
        do_cmd(10, 5, 0, "R6 R12 read w1");

        // R3: store wiper1 into shadow word 1
        do_cmd(2, 1, 0, "R3 store w1");
        nv_read(1, "R3 shadow1");
        nv_read(0, "R3 shadow0 untouched");
        do_cmd(11, 1, 7, "R2 set w1");
        do_cmd(1, 1, 0, "R2 load1 w1");

        // R7: preset acts on the rising edge only
        do_cmd(11, 0, 55, "R7 prep w0");
        do_preset_rise("R7 rise");
        do_cmd(11, 0, 9, "R7 w0 while high");
        @(negedge clk);
        preset_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 fall ready", int'(ready), 1);
        check_wipers("R7 fall");

        // R8: write protect
        wp_n = 1'b0;
        do_cmd(11, 0, 77, "R8 set blocked");
        do_cmd(3, 5, 321, "R8 wrnv blocked");
        nv_read(5, "R8 word5");
        do_cmd(2, 0, 0, "R8 store blocked");
        nv_read(0, "R8 shadow0");
        do_cmd(8, 0, 0, "R8 load all allowed");
        wp_n = 1'b1;
        do_cmd(11, 1, 33, "R8 set after");
        wp_n = 1'b0;
        do_cmd(1, 1, 0, "R8 load1 allowed");
        do_cmd(11, 0, 66, "R8 set blocked2");
        @(negedge clk); preset_in = 1'b0;
        do_preset_rise("R8 preset allowed");
        @(negedge clk); preset_in = 1'b0;
        wp_n = 1'b1;

        // R9: requests during a busy window are dropped and flagged
        do_cmd(11, 1, 444, "R9 prep w1");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'd2; cmd_addr = '0; cmd_data = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 store started", int'(ready), 0);
        cmd_valid = 1'b1; cmd_code = 4'd11; cmd_addr = AW'(1); cmd_data = WW'(5);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 err on cmd", int'(err), 1);
        preset_in = 1'b1;
        @(negedge clk);
        check("R9 err on preset", int'(err), 1);
        preset_in = 1'b0;
        @(negedge clk);
        check("R9 err clears", int'(err), 0);
        busy = 0;
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        check("R9 remaining store window", busy, LONG - 3);
        check("R9 no rd_valid", int'(rd_valid), 0);
        nv_m[0] = w_m[0];
        check_wipers("R9 dropped");
        nv_read(0, "R9 store landed");

        // R10: preset and command in the same idle cycle
        @(negedge clk);
        preset_in = 1'b1;
        cmd_valid = 1'b1; cmd_code = 4'd11; cmd_addr = '0; cmd_data = WW'(300);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 err", int'(err), 1);
        busy = 0;
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        check("R10 preset busy", busy, PRE);
        w_m[0] = nv_m[0]; w_m[1] = nv_m[1];
        check_wipers("R10 preset wins");
        @(negedge clk); preset_in = 1'b0;

        // R11: every code swept, plus out-of-range addresses
        for (int c = 0; c < 16; c++) begin
            if (c != 1 && c != 11) do_cmd(c, 4, 0, "R11 code sweep");
        end
        for (int a = NVW; a < (1 << AW); a++) begin
            do_cmd(3, a, 1, "R11 wrnv out of range");
            do_cmd(9, a, 0, "R11 rdnv out of range");
        end
        nv_read(4, "R11 word4");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule